// File: doc/BRIEF.md
# Steerable Timer PWM Generator

This block produces one pulse-width modulated waveform from a free-running 8-bit timer and routes it to any combination of four output pins. The timer is fed by a prescaler with three division ratios and counts from zero up to a programmable period value, then wraps. Each wrap is a period boundary. At a boundary the output goes high, a sticky interrupt flag is raised, and a new 10-bit duty value is taken from shadow registers. The output falls when a 10-bit extended count (timer value plus two fractional prescaler bits) reaches the latched duty value.

Software configures the block through a single-cycle register write port. A sleep input freezes the whole block: timer, prescaler, output level, flag and every register hold their values, and writes are ignored. When sleep is released, counting resumes from the held state. Each pin has an output-enable bit, and all enables are off after reset so the pins start as inputs.

Top module: `pwm_steer_gen`

## Requirements
- R1: After reset the timer reads 0, the period register holds 255, the duty, steering, output-enable and control registers hold 0, the interrupt flag is 0, all pins are low and all output enables are off.
- R2: Control register (address 0) bit 2 runs the timer, and bits 1:0 pick the prescaler: 00 gives one timer step every 4 clocks, 01 every 16 clocks, 1x every 64 clocks. The extended count advances every 1, 4 or 16 clocks. With bit 2 clear the timer holds its value.
- R3: While sleep_i is high the timer, prescaler, output level, flag and all registers keep their values, and register writes (including flag clears) have no effect.
- R4: After sleep_i falls the timer continues from its held value; exactly four enabled clocks later at divide-by-1 it reads one more than before sleep.
- R5: The timer counts 0 up to the period register (address 1) and wraps to 0, so a PWM period lasts (PERIOD+1)*4*div clocks.
- R6: The duty value D is {DUTY_HI (address 2), DUTY_LO (address 3) bits 1:0}. At each boundary the output rises (if D is non-zero) and stays high for D*div clocks.
- R7: With D equal to 0 the output stays low for whole periods; with D larger than 4*PERIOD+3 it stays high for whole periods.
- R8: A duty write takes effect only at the next period boundary; the running period keeps its old high time.
- R9: The interrupt flag is set at each period boundary and stays set until a write to address 6 with data bit 0 equal to 1 clears it; a write to address 6 with bit 0 equal to 0 leaves it set.
- R10: Steering register (address 4) bit i routes the waveform to pin i; an unselected pin drives 0. Output-enable register (address 5) bit i drives pwm_oe_o[i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freezes all state while high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| pwm_o | output | 4 | Steered PWM pin levels |
| pwm_oe_o | output | 4 | Per-pin output enable |
| irq_flag_o | output | 1 | Sticky period-match flag |
| timer_o | output | 8 | Current timer value |

## Verification
The bench builds the block with its default 8-bit data and timer width and four pins. Small period values keep every divider's full period within a few hundred clocks, so period and high time are measured exactly for all three ratios, and the full 10-bit duty range reaches both the always-low and always-high cases. Four pins let steering be checked on disjoint patterns, with a sleep window placed inside a high phase so a frozen level is seen at the pins.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  localparam int PRE_W = 6;

  typedef enum logic [2:0] {
    REG_TCTRL    = 3'd0,
    REG_PERIOD   = 3'd1,
    REG_DUTY_HI  = 3'd2,
    REG_DUTY_LO  = 3'd3,
    REG_STEER    = 3'd4,
    REG_OE       = 3'd5,
    REG_FLAG_CLR = 3'd6
  } reg_addr_e;

  // Clocks per extended-count step for a prescaler code.
  function automatic int unsigned ps_div(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      default: return 16;
    endcase
  endfunction

  // Last prescaler value before a timer step.
  function automatic logic [PRE_W-1:0] ps_last(input logic [1:0] sel);
    return PRE_W'(4 * ps_div(sel) - 1);
  endfunction

  // Two fractional bits appended to the timer for the duty compare.
  function automatic logic [1:0] ps_frac(input logic [PRE_W-1:0] pc,
                                         input logic [1:0] sel);
    case (sel)
      2'b00:   return pc[1:0];
      2'b01:   return pc[3:2];
      default: return pc[5:4];
    endcase
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_steer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NPIN   = 4,
  localparam int DUTY_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              boundary_i,
  output logic              run_o,
  output logic [1:0]        ps_o,
  output logic [DATA_W-1:0] period_o,
  output logic [DUTY_W-1:0] duty_sh_o,
  output logic [NPIN-1:0]   steer_o,
  output logic [NPIN-1:0]   oe_o,
  output logic              flag_o
);

  logic              wr_ok;
  logic              flag_clr;
  logic [DATA_W-1:0] duty_hi;
  logic [1:0]        duty_lo;

  assign wr_ok    = wr_en_i && !sleep_i;
  assign flag_clr = wr_ok && (reg_addr_e'(wr_addr_i) == REG_FLAG_CLR) && wr_data_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_o    <= 1'b0;
      ps_o     <= 2'b00;
      period_o <= '1;
      duty_hi  <= '0;
      duty_lo  <= '0;
      steer_o  <= '0;
      oe_o     <= '0;
    end else if (wr_ok) begin
      case (reg_addr_e'(wr_addr_i))
        REG_TCTRL: begin
          run_o <= wr_data_i[2];
          ps_o  <= wr_data_i[1:0];
        end
        REG_PERIOD:  period_o <= wr_data_i;
        REG_DUTY_HI: duty_hi  <= wr_data_i;
        REG_DUTY_LO: duty_lo  <= wr_data_i[1:0];
        REG_STEER:   steer_o  <= wr_data_i[NPIN-1:0];
        REG_OE:      oe_o     <= wr_data_i[NPIN-1:0];
        default: ;
      endcase
    end
  end

  // Set has priority over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_o <= 1'b0;
    else if (boundary_i) flag_o <= 1'b1;
    else if (flag_clr)   flag_o <= 1'b0;
  end

  assign duty_sh_o = {duty_hi, duty_lo};

  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i |=> flag_o);
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr) |=> flag_o);
  a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(boundary_i));
  a_r3_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(steer_o) && $stable(period_o) && $stable(duty_sh_o)
                 && $stable(flag_o) && $stable(oe_o)));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_steer_pkg::*;
#(
  parameter int TMR_W = 8,
  localparam int EXT_W = TMR_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             run_i,
  input  logic [1:0]       ps_i,
  input  logic [TMR_W-1:0] period_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic [EXT_W-1:0] ext_nxt_o,
  output logic             step_o,
  output logic             boundary_o
);

  logic [PRE_W-1:0] pc, pc_nxt;
  logic [TMR_W-1:0] tmr_nxt;
  logic             tick;

  assign step_o     = run_i && !sleep_i;
  assign tick       = step_o && (pc >= ps_last(ps_i));
  assign boundary_o = tick && (tmr_o == period_i);

  always_comb begin
    pc_nxt  = pc;
    tmr_nxt = tmr_o;
    if (step_o) pc_nxt = tick ? '0 : pc + 1'b1;
    if (tick)   tmr_nxt = boundary_o ? '0 : tmr_o + 1'b1;
  end

  assign ext_nxt_o = {tmr_nxt, ps_frac(pc_nxt, ps_i)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc    <= '0;
      tmr_o <= '0;
    end else begin
      pc    <= pc_nxt;
      tmr_o <= tmr_nxt;
    end
  end

  a_r3_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(tmr_o) && $stable(pc)));
  a_r2_timer_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(tmr_o));
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_o |=> (tmr_o == '0));
  a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !boundary_o) |=> (tmr_o == $past(tmr_o) + 1'b1));

endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
  parameter int EXT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             boundary_i,
  input  logic [EXT_W-1:0] ext_nxt_i,
  input  logic [EXT_W-1:0] duty_sh_i,
  output logic             pwm_o
);

  logic [EXT_W-1:0] duty_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_lat <= '0;
      pwm_o    <= 1'b0;
    end else if (boundary_i) begin
      duty_lat <= duty_sh_i;
      pwm_o    <= (duty_sh_i != '0);
    end else if (step_i && (ext_nxt_i == duty_lat)) begin
      pwm_o    <= 1'b0;
    end
  end

  a_r6_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o) |-> $past(boundary_i));
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> $stable(duty_lat));
  a_r3_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !boundary_i) |=> $stable(pwm_o));

endmodule

// File: rtl/pwm_steer.sv
module pwm_steer #(
  parameter int   NPIN     = 4,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic            pwm_i,
  input  logic [NPIN-1:0] steer_i,
  output logic [NPIN-1:0] pin_o
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign pin_o[i] = steer_i[i] ? pwm_i : IDLE_LVL;
  end

endmodule

// File: rtl/pwm_steer_gen.sv
module pwm_steer_gen
  import pwm_steer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NPIN   = 4,
  localparam int TMR_W = DATA_W,
  localparam int EXT_W = TMR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NPIN-1:0]   pwm_o,
  output logic [NPIN-1:0]   pwm_oe_o,
  output logic              irq_flag_o,
  output logic [TMR_W-1:0]  timer_o
);

  logic             run, step, boundary, pwm_raw;
  logic [1:0]       ps;
  logic [TMR_W-1:0] period;
  logic [EXT_W-1:0] duty_sh, ext_nxt;
  logic [NPIN-1:0]  steer;

  pwm_regs #(.DATA_W(DATA_W), .NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .boundary_i(boundary),
    .run_o(run), .ps_o(ps), .period_o(period), .duty_sh_o(duty_sh),
    .steer_o(steer), .oe_o(pwm_oe_o), .flag_o(irq_flag_o)
  );

  pwm_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .run_i(run), .ps_i(ps), .period_i(period),
    .tmr_o(timer_o), .ext_nxt_o(ext_nxt),
    .step_o(step), .boundary_o(boundary)
  );

  pwm_duty #(.EXT_W(EXT_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .step_i(step), .boundary_i(boundary),
    .ext_nxt_i(ext_nxt), .duty_sh_i(duty_sh), .pwm_o(pwm_raw)
  );

  pwm_steer #(.NPIN(NPIN), .IDLE_LVL(1'b0)) u_steer (
    .pwm_i(pwm_raw), .steer_i(steer), .pin_o(pwm_o)
  );

  a_r3_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> $stable(pwm_o));

endmodule

// File: tb/pwm_steer_gen_bench.sv
module pwm_steer_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] pwm_o, pwm_oe_o;
  logic       irq_flag_o;
  logic [7:0] timer_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwm_steer_gen u_pwm_steer_gen (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .irq_flag_o(irq_flag_o),
    .timer_o(timer_o)
  );

  typedef struct {int high; int per; string tag;} exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: measures pin 0 and pops one expected item per full period.
  bit mon_en = 0;
  bit prev = 0, have_rise = 0;
  int cyc = 0, last_rise = 0, last_high = 0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!mon_en) begin
      have_rise = 0;
      prev = pwm_o[0];
    end else begin
      if (pwm_o[0] && !prev) begin
        if (have_rise && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          check(last_high == e.high, {e.tag, " high time"}, last_high, e.high);
          check(cyc - last_rise == e.per, {e.tag, " period"}, cyc - last_rise, e.per);
        end
        have_rise = 1;
        last_rise = cyc;
      end
      if (!pwm_o[0] && prev) last_high = cyc - last_rise;
      prev = pwm_o[0];
    end
  end

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en_i = 1'b1;
    wr_addr_i = 3'(addr);
    wr_data_i = 8'(data);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic reset_dut();
    mon_en = 0;
    sleep_i = 1'b0;
    wr_en_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (!pwm_o[0]) @(negedge clk);
  endtask

  task automatic measure_high(output int h);
    h = 0;
    while (pwm_o[0]) begin
      h++;
      @(negedge clk);
    end
  endtask

  // Driver: configures a case and pushes the expected waveform items.
  task automatic run_case(input int ps, input int per, input int duty, input int n, input string tag);
    int div;
    div = (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
    reset_dut();
    wr(1, per);
    wr(2, duty >> 2);
    wr(3, duty & 3);
    wr(4, 1);
    mon_en = 1;
    for (int i = 0; i < n; i++) exp_q.push_back('{duty * div, (per + 1) * 4 * div, tag});
    wr(0, 4 | ps);
    while (exp_q.size() != 0) @(negedge clk);
    mon_en = 0;
  endtask

  initial begin
    int h, t0, f0, cnt;
    logic [3:0] p0;

    reset_dut();
    // R1: reset state
    check(timer_o == 0, "R1 timer", int'(timer_o), 0);
    check(pwm_o == 0, "R1 pins", int'(pwm_o), 0);
    check(pwm_oe_o == 0, "R1 oe", int'(pwm_oe_o), 0);
    check(irq_flag_o == 0, "R1 flag", int'(irq_flag_o), 0);

    // R2: timer holds while run bit is clear
    wr(1, 5);
    repeat (50) @(negedge clk);
    check(timer_o == 0, "R2 idle timer", int'(timer_o), 0);

    // R2, R5, R6: waveform for each prescaler code
    run_case(0, 9, 13, 3, "R2 R5 R6 ps00");
    run_case(1, 4, 7, 3, "R2 R5 R6 ps01");
    run_case(2, 3, 10, 3, "R2 R5 R6 ps10");
    run_case(3, 1, 5, 3, "R2 R5 R6 ps11");

    // R7: zero duty stays low
    reset_dut();
    wr(1, 3); wr(4, 1); wr(0, 4);
    cnt = 0;
    repeat (200) begin @(negedge clk); if (pwm_o[0]) cnt++; end
    check(cnt == 0, "R7 zero duty high cycles", cnt, 0);

    // R7 and R10: full duty with steering and output enables
    reset_dut();
    wr(1, 3); wr(2, 255); wr(3, 3); wr(4, 4'b0101); wr(0, 4);
    repeat (40) @(negedge clk);
    cnt = 0;
    repeat (100) begin @(negedge clk); if (pwm_o != 4'b0101) cnt++; end
    check(cnt == 0, "R7 R10 full duty pattern 0101 mismatches", cnt, 0);
    wr(4, 4'b1010);
    check(pwm_o == 4'b1010, "R10 steer 1010", int'(pwm_o), 4'b1010);
    check(pwm_oe_o == 0, "R10 oe untouched", int'(pwm_oe_o), 0);
    wr(5, 4'b0011);
    check(pwm_oe_o == 4'b0011, "R10 oe 0011", int'(pwm_oe_o), 4'b0011);
    check(pwm_o == 4'b1010, "R10 pins after oe write", int'(pwm_o), 4'b1010);

    // R8: duty write inside a high phase
    reset_dut();
    wr(1, 9); wr(3, 0); wr(2, 2); wr(4, 1); wr(0, 4);
    wait_rise();
    fork wr(2, 5); join_none
    measure_high(h);
    check(h == 8, "R8 old duty kept", h, 8);
    wait_rise();
    measure_high(h);
    check(h == 20, "R8 new duty after boundary", h, 20);

    // R9: flag behaviour
    reset_dut();
    wr(1, 15); wr(2, 4); wr(4, 1); wr(0, 4 | 1);
    while (!irq_flag_o) @(negedge clk);
    repeat (20) @(negedge clk);
    check(irq_flag_o == 1, "R9 flag sticky", int'(irq_flag_o), 1);
    wr(6, 0);
    check(irq_flag_o == 1, "R9 write bit0=0 keeps flag", int'(irq_flag_o), 1);
    wr(6, 1);
    check(irq_flag_o == 0, "R9 flag cleared", int'(irq_flag_o), 0);
    repeat (300) @(negedge clk);
    check(irq_flag_o == 1, "R9 flag set at next boundary", int'(irq_flag_o), 1);

    // R3, R4: sleep inside a high phase
    reset_dut();
    wr(1, 20); wr(2, 20); wr(4, 1); wr(0, 4);
    wait_rise();
    repeat (10) @(negedge clk);
    t0 = int'(timer_o); p0 = pwm_o; f0 = int'(irq_flag_o);
    sleep_i = 1'b1;
    wr(4, 0);
    wr(6, 1);
    wr(0, 0);
    repeat (50) @(negedge clk);
    check(int'(timer_o) == t0, "R3 timer frozen", int'(timer_o), t0);
    check(pwm_o == p0, "R3 pins frozen", int'(pwm_o), int'(p0));
    check(int'(irq_flag_o) == f0, "R3 flag frozen", int'(irq_flag_o), f0);
    sleep_i = 1'b0;
    repeat (4) @(negedge clk);
    check(int'(timer_o) == t0 + 1, "R4 resume count", int'(timer_o), t0 + 1);
    check(pwm_o == 4'b0001, "R3 writes ignored in sleep", int'(pwm_o), 1);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule